// File: doc/BRIEF.md
# Programmable Page-Mapped Address Decoder

This block turns the 16-bit address bus of an 8-bit processor into six active-low chip selects and a pair of register-window strobes. It does not use fixed gates. Each of the 256 pages of 256 bytes has one byte in a writable map, and the low three bits of that byte name the target of the page. Codes 0 to 5 choose a chip select, and select 0 is the one given to main RAM. Code 6 sends the access to an internal register window. Code 7 leaves the page unmapped.

A loader port writes map entries at run time and can read any entry back. This lets one board take on a different memory layout, or move an I/O page to another address, with no change to the wiring. While the loader is active, every output stays inactive, so the processor never decodes through a map that is only partly written. The decode path is combinational from the address to the outputs, so it fits well inside a 1 MHz bus cycle.

Top module: `page_decoder`

## Requirements
- R1: The page index is addr[15:8]. When that page's entry has low bits 0 to 5 (code k), only cs_n[k] goes low.
- R2: Code 6 asserts no chip select. It raises win_rd when rw is 1 (read) and raises win_wr when rw is 0 (write).
- R3: Code 7 asserts nothing. Bits [7:3] of an entry have no effect on the decode.
- R4: All outputs are inactive (cs_n all 1, win_rd and win_wr 0) while phi2 is low.
- R5: All outputs are inactive while ld_busy or ld_we is high.
- R6: After reset the map holds these bytes: 0x00 on pages 0x00-0x7F, 0x06 on page 0x80, 0x01 on pages 0xF0-0xFF, and 0x07 on every other page.
- R7: A rising clock edge with ld_we high stores ld_data at page ld_page. ld_rdata always shows the full stored byte of page ld_page.
- R8: At most one of the eight outputs (six selects and two window strobes) is active at any time.
- R9: Rewriting entries moves the register window. The old page then decodes by its new entry and the new page gives window strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the default map |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Bus clock phase; outputs are enabled only while it is high |
| ld_busy | input | 1 | Loader session active; holds all outputs inactive |
| ld_we | input | 1 | Map write strobe |
| ld_page | input | 8 | Page index for a loader write or read-back |
| ld_data | input | 8 | Entry byte to write |
| ld_rdata | output | 8 | Stored entry of page ld_page |
| cs_n | output | 6 | Active-low chip selects |
| win_rd | output | 1 | Register-window read strobe |
| win_wr | output | 1 | Register-window write strobe |

## Verification
On every cycle the assertions check that at most one output is active, that nothing is active while phi2 is low or the loader holds the bus, that a window strobe follows the rw direction, and that a loader write can be read back on the next cycle. The bench scenarios are what show the actual map contents. These include the reset layout, the decode of each code on chosen addresses, that the upper entry bits are ignored, and that the register window moves to a new page after the map is rewritten.

// File: rtl/page_dec_pkg.sv
package page_dec_pkg;
  localparam int ADDR_W   = 16;
  localparam int PAGE_W   = 8;
  localparam int PAGES    = 1 << PAGE_W;
  localparam int ENTRY_W  = 8;
  localparam int NUM_CS   = 6;
  localparam int CODE_W   = 3;
  localparam logic [CODE_W-1:0] WIN_CODE  = CODE_W'(NUM_CS);
  localparam logic [CODE_W-1:0] NONE_CODE = CODE_W'(NUM_CS + 1);

  // Default layout: RAM low half, window at 0x80, select 1 on top 16 pages.
  function automatic logic [ENTRY_W-1:0] default_entry(input logic [PAGE_W-1:0] pg);
    if (pg < 8'h80)        return 8'h00;
    else if (pg == 8'h80)  return ENTRY_W'(WIN_CODE);
    else if (pg >= 8'hF0)  return 8'h01;
    else                   return ENTRY_W'(NONE_CODE);
  endfunction

  function automatic logic [CODE_W-1:0] entry_code(input logic [ENTRY_W-1:0] e);
    return e[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/page_map_store.sv
module page_map_store
  import page_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_idx,
  input  logic [ENTRY_W-1:0] wr_val,
  input  logic [PAGE_W-1:0]  bus_idx,
  output logic [ENTRY_W-1:0] bus_entry,
  output logic [ENTRY_W-1:0] rd_entry
);
  logic [ENTRY_W-1:0] map_q [PAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) map_q[i] <= default_entry(PAGE_W'(i));
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_val;
    end
  end

  assign bus_entry = map_q[bus_idx];
  assign rd_entry  = map_q[wr_idx];

  // R7
  map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/page_sel_decode.sv
module page_sel_decode
  import page_dec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  input  logic              rw,
  output logic [NUM_CS-1:0] cs_n,
  output logic              win_rd,
  output logic              win_wr
);
  logic win_hit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(enable && (code == CODE_W'(g)));
  end

  assign win_hit = enable && (code == WIN_CODE);
  assign win_rd  = win_hit && rw;
  assign win_wr  = win_hit && !rw;
endmodule

// File: rtl/page_decoder.sv
module page_decoder
  import page_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rw,
  input  logic               phi2,
  input  logic               ld_busy,
  input  logic               ld_we,
  input  logic [PAGE_W-1:0]  ld_page,
  input  logic [ENTRY_W-1:0] ld_data,
  output logic [ENTRY_W-1:0] ld_rdata,
  output logic [NUM_CS-1:0]  cs_n,
  output logic               win_rd,
  output logic               win_wr
);
  logic [PAGE_W-1:0]  bus_page;
  logic [ENTRY_W-1:0] bus_entry;
  logic [CODE_W-1:0]  bus_code;
  logic               load_hold;
  logic               dec_en;

  assign bus_page  = addr[ADDR_W-1 -: PAGE_W];
  assign load_hold = ld_busy | ld_we;
  assign dec_en    = phi2 & ~load_hold;
  assign bus_code  = entry_code(bus_entry);

  page_map_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_we), .wr_idx(ld_page), .wr_val(ld_data),
    .bus_idx(bus_page), .bus_entry(bus_entry), .rd_entry(ld_rdata)
  );

  page_sel_decode u_dec (
    .code(bus_code), .enable(dec_en), .rw(rw),
    .cs_n(cs_n), .win_rd(win_rd), .win_wr(win_wr)
  );

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~cs_n, win_rd, win_wr}));
  // R4
  phase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (&cs_n && !win_rd && !win_wr));
  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_busy || ld_we) |-> (&cs_n && !win_rd && !win_wr));
  // R2
  win_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd || win_wr) |-> (&cs_n && (win_rd == rw)));
endmodule

// File: tb/page_decoder_tb.sv
module page_decoder_tb;
  localparam int CLK_PERIOD = 10;
  // {addr[16], rw, phi2, exp_cs_n[6], exp_rd, exp_wr}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {16'h0012, 1'b1, 1'b1, 6'b111110, 1'b0, 1'b0},
    {16'h7FFF, 1'b0, 1'b1, 6'b111110, 1'b0, 1'b0},
    {16'h8005, 1'b1, 1'b1, 6'b111111, 1'b1, 1'b0},
    {16'h80FF, 1'b0, 1'b1, 6'b111111, 1'b0, 1'b1},
    {16'hF000, 1'b1, 1'b1, 6'b111101, 1'b0, 1'b0},
    {16'hFFFF, 1'b0, 1'b1, 6'b111101, 1'b0, 1'b0},
    {16'h9000, 1'b1, 1'b1, 6'b111111, 1'b0, 1'b0},
    {16'h81AA, 1'b0, 1'b1, 6'b111111, 1'b0, 1'b0},
    {16'h0012, 1'b1, 1'b0, 6'b111111, 1'b0, 1'b0},
    {16'h8005, 1'b1, 1'b0, 6'b111111, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] addr = '0;
  logic rw = 1, phi2 = 0, ld_busy = 0, ld_we = 0;
  logic [7:0] ld_page = '0, ld_data = '0, ld_rdata;
  logic [5:0] cs_n;
  logic win_rd, win_wr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2),
    .ld_busy(ld_busy), .ld_we(ld_we), .ld_page(ld_page), .ld_data(ld_data),
    .ld_rdata(ld_rdata), .cs_n(cs_n), .win_rd(win_rd), .win_wr(win_wr)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {cs_n, win_rd, win_wr};
  endfunction

  task automatic bus(input logic [15:0] a, input logic r, input logic p);
    @(negedge clk); addr = a; rw = r; phi2 = p; #1;
  endtask

  task automatic load(input logic [7:0] pg, input logic [7:0] d);
    @(negedge clk); ld_page = pg; ld_data = d; ld_we = 1;
    @(negedge clk); ld_we = 0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R6 reset contents through read-back
    @(negedge clk); ld_page = 8'h00; #1; chk("R6 page00", ld_rdata, 8'h00);
    ld_page = 8'h7F; #1; chk("R6 page7F", ld_rdata, 8'h00);
    ld_page = 8'h80; #1; chk("R6 page80", ld_rdata, 8'h06);
    ld_page = 8'hA5; #1; chk("R6 pageA5", ld_rdata, 8'h07);
    ld_page = 8'hF7; #1; chk("R6 pageF7", ld_rdata, 8'h01);
    // R1 R2 R3 R4 table walk on the default map
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][25:10], VEC[i][9], VEC[i][8]);
      chk("R1/R2/R3/R4 vector", outs(), VEC[i][7:0]);
    end
    // R7 write and read back full byte
    load(8'h90, 8'hA3);
    ld_page = 8'h90; #1; chk("R7 readback", ld_rdata, 8'hA3);
    bus(16'h9044, 1, 1); chk("R1 code3", outs(), {6'b110111, 2'b00});
    // R3 upper bits ignored: 0xFD -> code 5, 0xF8 -> code 0, 0x5F -> code 7
    load(8'h90, 8'hFD); bus(16'h9001, 0, 1); chk("R3 upper bits code5", outs(), {6'b011111, 2'b00});
    load(8'h90, 8'hF8); bus(16'h9001, 1, 1); chk("R3 upper bits code0", outs(), {6'b111110, 2'b00});
    load(8'h90, 8'h5F); bus(16'h9001, 1, 1); chk("R3 code7 unmapped", outs(), 8'hFC);
    // R9 relocate window from 0x80 to 0xC0
    load(8'h80, 8'h04); load(8'hC0, 8'h06);
    bus(16'h8010, 1, 1); chk("R9 old page now cs4", outs(), {6'b101111, 2'b00});
    bus(16'hC010, 1, 1); chk("R9 new window read", outs(), 8'hFE);
    bus(16'hC010, 0, 1); chk("R9 new window write", outs(), 8'hFD);
    // R5 busy and write strobe hold outputs inactive
    ld_busy = 1; #1; chk("R5 busy hold", outs(), 8'hFC);
    ld_busy = 0; #1; chk("R5 busy release", outs(), 8'hFD);
    bus(16'h0000, 1, 1);
    ld_page = 8'h55; ld_data = 8'h07; ld_we = 1; #1;
    chk("R5 write strobe hold", outs(), 8'hFC);
    @(negedge clk); ld_we = 0; #1;
    chk("R5 after write", outs(), {6'b111110, 2'b00});
    // R8 quick sweep of mapped pages: at most one active output
    foreach (VEC[i]) begin
      bus(VEC[i][25:10], VEC[i][9], 1);
      chk("R8 one active", 8'($countones(outs() ^ 8'hFC) <= 1), 8'h01);
    end
    // R6 reset restores default after rewrites
    rst_n = 0; #1; rst_n = 1;
    ld_page = 8'h80; #1; chk("R6 reset restores window", ld_rdata, 8'h06);
    ld_page = 8'hC0; #1; chk("R6 reset clears C0", ld_rdata, 8'h07);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule